// File: doc/BRIEF.md
# Peripheral Mode and Soft-Reset Controller

This block holds the mode-control bits of a serial communication peripheral and decides which operating state the peripheral is in. A CPU writes a small control word that holds freeze enable, halt, receive-queue enable, wake-interrupt mask and a soft-reset trigger. It reads the same word back, with three status bits added. The block resolves those bits, together with external stop and disable requests, into one of four modes. It tells the bit engine whether it may transmit or receive. It also reports a freeze acknowledge once the engine confirms that it is idle.

A soft reset is a four-phase handshake into a slower protocol clock domain. The request level crosses a synchronizer chain, and the protocol side answers with an acknowledge and emits a one-cycle reset pulse for its own state machines. The acknowledge returns through a second chain. The trigger bit stays readable as 1 until the returning acknowledge is seen, so software polls it. Both freeze entry and soft reset are refused while a low-power mode is active.

Top module: `periph_mode_ctrl`

## Requirements
- R1: After reset the control word reads 0x00, mode_o is 0 (normal), not_ready is 0, txrx_en is 1 and frz_ack is 0.
- R2: mode_o becomes 1 (freeze) within two cycles of a write only when halt (bit 1) and freeze enable (bit 0) are both 1. Halt alone leaves mode_o at 0.
- R3: txrx_en is 0 whenever halt is 1 or the mode is not normal. It returns to 1 only after halt is cleared in normal mode.
- R4: The disable request (mode 3) takes priority over the stop request (mode 2), and both take priority over freeze. While the block is in mode 2 or 3, halt with freeze enable does not enter freeze. After the requests drop, the block passes through normal.
- R5: not_ready (also read at bit 5) is 1 in modes 1, 2 and 3 and 0 in mode 0.
- R6: frz_ack (also read at bit 6) rises once the block is in freeze and core_idle is 1. It falls one cycle after the mode leaves freeze.
- R7: The receive-queue enable (bit 2) takes a written value only when the write happens in freeze mode. Otherwise it keeps its value.
- R8: Writing 1 to bit 4 outside low power sets the pending flag, read at bit 4. This starts the handshake: the protocol side emits exactly one proto_srst pulse, and bit 4 clears by itself after the synchronized acknowledge returns. A second request is accepted only after the acknowledge has dropped.
- R9: A soft-reset request written while the low-power flag (bit 7, set in modes 2 and 3) is 1 is discarded.
- R10: Writing 0 to bit 4 does not clear a pending soft reset. On completion, halt, receive-queue enable and wake mask (bit 3) return to 0, freeze enable keeps its value, and not_ready is not forced.
- R11: Bits 5 to 7 of the control word are read-only, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and mode clock |
| rst | input | 1 | Synchronous active-high reset, clk domain |
| proto_clk | input | 1 | Slower protocol-engine clock |
| proto_rst | input | 1 | Synchronous active-high reset, proto_clk domain |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | DATA_W | Control-word write value |
| rd_data | output | DATA_W | Registered control and status word |
| stop_req | input | 1 | Request to enter stop (low power) mode |
| dis_req | input | 1 | Request to enter disable mode |
| core_idle | input | 1 | Bit engine reports that it is idle |
| mode_o | output | 2 | 0 normal, 1 freeze, 2 stop, 3 disable |
| not_ready | output | 1 | High in any mode other than normal |
| frz_ack | output | 1 | Freeze acknowledged |
| txrx_en | output | 1 | Bit engine may transmit and receive |
| proto_srst | output | 1 | One-cycle soft-reset pulse in proto_clk domain |

## Verification
A mode register that goes wrong shows within two cycles on mode_o, not_ready and txrx_en, and one cycle later on the read word. The directed scenarios therefore sample these ports a few cycles after each write or request change, and the freeze-exit case is sampled cycle by cycle. A broken handshake shows up in one of three ways: bit 4 never clears within the poll bound, it clears without a proto_srst pulse, or it leaves halt, wake or receive-queue enable set. Bits that must be ignored are read back through rd_data after the write that tried to change them.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    M_NORMAL  = 2'd0,
    M_FREEZE  = 2'd1,
    M_STOP    = 2'd2,
    M_DISABLE = 2'd3
  } pmc_mode_e;

  // control word bit positions
  localparam int B_FRZ_EN = 0;
  localparam int B_HALT   = 1;
  localparam int B_QUEUE  = 2;
  localparam int B_WAKE   = 3;
  localparam int B_SRST   = 4;
  localparam int B_NRDY   = 5;
  localparam int B_FACK   = 6;
  localparam int B_LPWR   = 7;
  localparam int MIN_W    = 8;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      halt,
  input  logic      frz_en,
  input  logic      stop_req,
  input  logic      dis_req,
  input  logic      core_idle,
  output pmc_mode_e mode_q,
  output logic      not_ready,
  output logic      low_pwr,
  output logic      txrx_en,
  output logic      frz_ack
);
  pmc_mode_e nxt;
  logic      in_lp;

  assign in_lp = (mode_q == M_STOP) || (mode_q == M_DISABLE);

  always_comb begin
    if (dis_req)              nxt = M_DISABLE;
    else if (stop_req)        nxt = M_STOP;
    else if (in_lp)           nxt = M_NORMAL;
    else if (halt && frz_en)  nxt = M_FREEZE;
    else                      nxt = M_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= M_NORMAL;
      not_ready <= 1'b0;
      low_pwr   <= 1'b0;
      txrx_en   <= 1'b1;
      frz_ack   <= 1'b0;
    end else begin
      mode_q    <= nxt;
      not_ready <= (nxt != M_NORMAL);
      low_pwr   <= (nxt == M_STOP) || (nxt == M_DISABLE);
      txrx_en   <= (nxt == M_NORMAL) && !halt;
      frz_ack   <= (mode_q == M_FREEZE) && core_idle;
    end
  end

  // R2
  frz_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_FREEZE) |-> $past(halt && frz_en));

  // R4
  no_frz_from_lp_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_lp) |-> (mode_q != M_FREEZE));

  // R4
  dis_wins_chk: assert property (@(posedge clk) disable iff (rst)
    $past(dis_req) |-> (mode_q == M_DISABLE));
endmodule

// File: rtl/pmc_ctrl_regs.sv
module pmc_ctrl_regs
  import pmc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              in_frz,
  input  logic              low_pwr,
  input  logic              ack_sync,
  output logic              frz_en,
  output logic              halt,
  output logic              queue_en,
  output logic              wake_msk,
  output logic              srst_pend
);
  logic ack_d;
  logic srst_done;
  logic hs_idle;
  logic unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:B_SRST+1];
  assign srst_done = ack_sync && !ack_d;
  assign hs_idle   = !ack_sync && !ack_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      frz_en    <= 1'b0;
      halt      <= 1'b0;
      queue_en  <= 1'b0;
      wake_msk  <= 1'b0;
      srst_pend <= 1'b0;
      ack_d     <= 1'b0;
    end else begin
      ack_d <= ack_sync;
      if (wr_en) begin
        frz_en   <= wr_data[B_FRZ_EN];
        halt     <= wr_data[B_HALT];
        wake_msk <= wr_data[B_WAKE];
        if (in_frz) queue_en <= wr_data[B_QUEUE];
        if (wr_data[B_SRST] && !low_pwr && !srst_pend && hs_idle)
          srst_pend <= 1'b1;
      end
      if (srst_done) begin
        halt      <= 1'b0;
        queue_en  <= 1'b0;
        wake_msk  <= 1'b0;
        srst_pend <= 1'b0;
      end
    end
  end

  // R7
  queue_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_frz) && !$past(srst_done)) |-> $stable(queue_en));

  // R9
  srst_not_in_lp_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(srst_pend) |-> !$past(low_pwr));

  // R8
  srst_clear_by_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(srst_pend) |-> $past(ack_sync));

  // R10
  srst_keeps_frz_chk: assert property (@(posedge clk) disable iff (rst)
    $past(srst_done && !wr_en) |-> (frz_en == $past(frz_en)) && !halt && !wake_msk);
endmodule

// File: rtl/pmc_proto_ack.sv
module pmc_proto_ack #(
  parameter int SYNC_STAGES = 2
) (
  input  logic proto_clk,
  input  logic proto_rst,
  input  logic req_async,
  output logic ack_q,
  output logic srst_pulse
);
  logic req_s;

  pmc_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
    .clk (proto_clk),
    .rst (proto_rst),
    .d   (req_async),
    .q   (req_s)
  );

  always_ff @(posedge proto_clk) begin
    if (proto_rst) begin
      ack_q      <= 1'b0;
      srst_pulse <= 1'b0;
    end else begin
      ack_q      <= req_s;
      srst_pulse <= req_s && !ack_q;
    end
  end

  // R8
  pulse_single_chk: assert property (@(posedge proto_clk) disable iff (proto_rst)
    srst_pulse |=> !srst_pulse);
endmodule

// File: rtl/periph_mode_ctrl.sv
module periph_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proto_clk,
  input  logic              proto_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              stop_req,
  input  logic              dis_req,
  input  logic              core_idle,
  output logic [1:0]        mode_o,
  output logic              not_ready,
  output logic              frz_ack,
  output logic              txrx_en,
  output logic              proto_srst
);
  localparam int PAD_W = DATA_W - MIN_W;

  pmc_mode_e   mode_q;
  logic        low_pwr;
  logic        frz_en, halt, queue_en, wake_msk, srst_pend;
  logic        ack_p, ack_sync;
  logic [MIN_W-1:0] rd_core;

  pmc_mode_fsm i_fsm (
    .clk       (clk),
    .rst       (rst),
    .halt      (halt),
    .frz_en    (frz_en),
    .stop_req  (stop_req),
    .dis_req   (dis_req),
    .core_idle (core_idle),
    .mode_q    (mode_q),
    .not_ready (not_ready),
    .low_pwr   (low_pwr),
    .txrx_en   (txrx_en),
    .frz_ack   (frz_ack)
  );

  pmc_ctrl_regs #(.DATA_W(DATA_W)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .in_frz    (mode_q == M_FREEZE),
    .low_pwr   (low_pwr),
    .ack_sync  (ack_sync),
    .frz_en    (frz_en),
    .halt      (halt),
    .queue_en  (queue_en),
    .wake_msk  (wake_msk),
    .srst_pend (srst_pend)
  );

  pmc_proto_ack #(.SYNC_STAGES(SYNC_STAGES)) i_proto (
    .proto_clk  (proto_clk),
    .proto_rst  (proto_rst),
    .req_async  (srst_pend),
    .ack_q      (ack_p),
    .srst_pulse (proto_srst)
  );

  pmc_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (ack_p),
    .q   (ack_sync)
  );

  always_comb begin
    rd_core           = '0;
    rd_core[B_FRZ_EN] = frz_en;
    rd_core[B_HALT]   = halt;
    rd_core[B_QUEUE]  = queue_en;
    rd_core[B_WAKE]   = wake_msk;
    rd_core[B_SRST]   = srst_pend;
    rd_core[B_NRDY]   = not_ready;
    rd_core[B_FACK]   = frz_ack;
    rd_core[B_LPWR]   = low_pwr;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= {{PAD_W{1'b0}}, rd_core};
      end
    end else begin : g_exact
      always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= rd_core;
      end
    end
  endgenerate

  assign mode_o = mode_q;

  // R3
  txrx_only_ready_chk: assert property (@(posedge clk) disable iff (rst)
    txrx_en |-> !not_ready);

  // R6
  fack_after_frz_chk: assert property (@(posedge clk) disable iff (rst)
    frz_ack |-> $past(not_ready));

  // R3
  txrx_blocked_by_halt_chk: assert property (@(posedge clk) disable iff (rst)
    $past(halt) |-> !txrx_en);
endmodule

// File: tb/test_periph_mode_ctrl.sv
`timescale 1ns/1ps
module test_periph_mode_ctrl;
  logic       clk = 1'b0;
  logic       proto_clk = 1'b0;
  logic       rst = 1'b1;
  logic       proto_rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       stop_req = 1'b0;
  logic       dis_req = 1'b0;
  logic       core_idle = 1'b0;
  logic [1:0] mode_o;
  logic       not_ready, frz_ack, txrx_en, proto_srst;

  int n_tests = 0;
  int n_fail  = 0;
  int pulses  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always #6 proto_clk = ~proto_clk;

  always @(posedge proto_clk) if (proto_srst) pulses++;

  periph_mode_ctrl i_periph_mode_ctrl (
    .clk(clk), .rst(rst), .proto_clk(proto_clk), .proto_rst(proto_rst),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .stop_req(stop_req), .dis_req(dis_req), .core_idle(core_idle),
    .mode_o(mode_o), .not_ready(not_ready), .frz_ack(frz_ack),
    .txrx_en(txrx_en), .proto_srst(proto_srst)
  );

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_word(logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic t_reset();
    wait_cyc(2);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 mode", mode_o, 0);
    chk("R1 not_ready", not_ready, 0);
    chk("R1 txrx_en", txrx_en, 1);
    chk("R1 frz_ack", frz_ack, 0);
  endtask

  task automatic t_halt_alone();
    write_word(8'h02);
    wait_cyc(3);
    chk("R2 halt alone mode", mode_o, 0);
    chk("R5 halt alone not_ready", not_ready, 0);
    chk("R3 halt blocks txrx", txrx_en, 0);
    chk("R2 halt alone rd", rd_data, 8'h02);
    write_word(8'hE0);
    wait_cyc(3);
    chk("R11 read-only bits ignore write", rd_data, 8'h00);
    chk("R3 txrx back", txrx_en, 1);
  endtask

  task automatic t_freeze();
    core_idle = 1'b0;
    write_word(8'h03);
    wait_cyc(3);
    chk("R2 freeze mode", mode_o, 1);
    chk("R5 freeze not_ready", not_ready, 1);
    chk("R6 no ack while busy", frz_ack, 0);
    chk("R3 freeze txrx", txrx_en, 0);
    chk("R2 freeze rd", rd_data, 8'h23);
    core_idle = 1'b1;
    wait_cyc(3);
    chk("R6 ack when idle", frz_ack, 1);
    chk("R6 ack rd", rd_data, 8'h63);
  endtask

  task automatic t_queue_and_exit();
    write_word(8'h07);
    wait_cyc(3);
    chk("R7 queue set in freeze", rd_data, 8'h67);
    write_word(8'h05);
    @(posedge clk); #1;
    chk("R2 exit mode", mode_o, 0);
    chk("R6 ack held one cycle", frz_ack, 1);
    @(posedge clk); #1;
    chk("R6 ack dropped", frz_ack, 0);
    wait_cyc(3);
    chk("R7 queue after exit", rd_data, 8'h05);
    write_word(8'h01);
    wait_cyc(3);
    chk("R7 queue write outside freeze ignored", rd_data, 8'h05);
    chk("R3 txrx normal", txrx_en, 1);
  endtask

  task automatic t_low_power();
    stop_req = 1'b1;
    wait_cyc(3);
    chk("R4 stop mode", mode_o, 2);
    chk("R5 stop not_ready", not_ready, 1);
    chk("R3 stop txrx", txrx_en, 0);
    chk("R9 lp flag rd", rd_data, 8'hA5);
    write_word(8'h07);
    wait_cyc(3);
    chk("R4 freeze ignored in stop", mode_o, 2);
    chk("R4 stop rd", rd_data, 8'hA7);
    pulses = 0;
    write_word(8'h17);
    wait_cyc(20);
    chk("R9 srst refused in low power", rd_data, 8'hA7);
    chk("R9 no proto pulse", pulses, 0);
    dis_req = 1'b1;
    wait_cyc(3);
    chk("R4 disable over stop", mode_o, 3);
    dis_req = 1'b0;
    stop_req = 1'b0;
    @(posedge clk); #1;
    chk("R4 leave lp via normal", mode_o, 0);
    wait_cyc(4);
    chk("R4 freeze after lp", mode_o, 1);
    chk("R6 ack after lp", rd_data, 8'h67);
  endtask

  task automatic t_soft_reset();
    bit seen_clear;
    pulses = 0;
    write_word(8'h1F);
    wait_cyc(2);
    chk("R8 pending visible", rd_data[4], 1);
    write_word(8'h0B);
    wait_cyc(1);
    chk("R10 zero write keeps pending", rd_data[4], 1);
    chk("R10 not_ready kept", not_ready, 1);
    seen_clear = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #1;
      if (!rd_data[4]) begin
        seen_clear = 1'b1;
        break;
      end
    end
    chk("R8 pending self-clears", seen_clear, 1);
    wait_cyc(4);
    chk("R10 fields after srst", rd_data, 8'h01);
    chk("R8 one proto pulse", pulses, 1);
    chk("R2 normal after srst", mode_o, 0);
    chk("R3 txrx after srst", txrx_en, 1);
    wait_cyc(20);
    write_word(8'h11);
    seen_clear = 1'b0;
    wait_cyc(2);
    chk("R8 second request accepted", rd_data[4], 1);
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #1;
      if (!rd_data[4]) begin
        seen_clear = 1'b1;
        break;
      end
    end
    chk("R8 second completion", seen_clear, 1);
    chk("R8 two proto pulses", pulses, 2);
  endtask

  initial begin
    repeat (6) @(posedge proto_clk);
    @(negedge clk);
    rst = 1'b0;
    proto_rst = 1'b0;
    t_reset();
    t_halt_alone();
    t_freeze();
    t_queue_and_exit();
    t_low_power();
    t_soft_reset();
    finished = 1'b1;
    report();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule